// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a program-generated virtual address into a physical address through a small table of segment descriptors that lives in registers. The top bits of the virtual address pick one descriptor and the rest of the address is the offset into that segment. Each descriptor has a base, a limit, three access permissions (read, write and execute), a presence flag, and two usage flags. The usage flags record that a segment has been touched and that it has been written.

A request is taken in on a valid/ready handshake, and its result appears one clock later. The base addition and the limit comparison are two independent pieces of logic that work on the raw offset in the same cycle. A fault is reported in one of two classes. A missing-segment fault means the descriptor is not present. A protection fault covers a limit overrun or an access type the descriptor does not allow.

Supervisor code loads descriptors through a separate write port and sets a mode bit that turns mapping on or off. While mapping is off, addresses pass through unchanged. A trap entry always turns mapping off.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. Exactly one clock later, `rsp_valid` is high for one cycle. At that point `rsp_paddr` equals the selected descriptor base plus the offset. The descriptor is selected by `req_vaddr[31:30]` and the offset is `req_vaddr[29:0]`.
- R2: When mapped, an offset strictly greater than the descriptor limit raises `rsp_prot_fault`. An offset equal to the limit is allowed.
- R3: `req_kind` encodes the access type: 00 read, 01 write, 10 execute, 11 reserved. The descriptor permission field holds read in bit 0, write in bit 1 and execute in bit 2. A mapped access whose permission bit is clear raises `rsp_prot_fault`. The reserved kind always raises it.
- R4: A mapped access to a descriptor whose presence flag is clear raises `rsp_seg_fault` and never `rsp_prot_fault`, even when the limit or the permissions would also fail. The two fault outputs are never high together, and neither is high without `rsp_valid`.
- R5: A mapped access that completes without a fault sets the descriptor's touched flag. A fault-free write also sets its written flag. Loading a descriptor clears both flags. The flags of the descriptor chosen by `st_idx` are visible on `st_touched` and `st_written`.
- R6: Mapping is off after reset. While it is off, `rsp_paddr` equals `req_vaddr`, no fault is raised, and no usage flag changes.
- R7: `trap_enter` clears the mapping bit at the next edge. It takes priority over a mode write in the same cycle.
- R8: A descriptor load (`ld_en`) or a mode write (`mode_wr`) takes effect only while `sup_mode` is high. Without `sup_mode` it changes nothing.
- R9: While `rst_n` is low, `req_ready` and `rsp_valid` are low. The reset is released through two flops, so `req_ready` goes high on the second rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access type (00 read, 01 write, 10 execute, 11 reserved) |
| sup_mode | input | 1 | Current code runs in supervisor mode |
| trap_enter | input | 1 | Trap entry; forces mapping off |
| mode_wr | input | 1 | Write the mapping mode bit |
| mode_wdata | input | 1 | New mapping mode value (1 = mapped) |
| ld_en | input | 1 | Load a descriptor |
| ld_idx | input | 2 | Descriptor to load |
| ld_base | input | 32 | Segment base |
| ld_limit | input | 30 | Highest legal offset |
| ld_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| ld_present | input | 1 | Presence flag |
| st_idx | input | 2 | Descriptor whose usage flags are shown |
| st_touched | output | 1 | Touched flag of descriptor `st_idx` |
| st_written | output | 1 | Written flag of descriptor `st_idx` |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address; meaningless when a fault is flagged |
| rsp_seg_fault | output | 1 | Missing-segment fault |
| rsp_prot_fault | output | 1 | Limit or permission fault |

## Verification
A wrong descriptor shows up at the ports on the very next response to that segment. A corrupted base gives a shifted `rsp_paddr`, and a corrupted limit, permission or presence flag gives the wrong fault class. A stale mapping bit shows up one cycle after the fault-free access that follows: a bypassed request comes back translated, or a mapped one comes back unchanged. A wrong usage flag is visible on the status outputs as soon as the access that should have set it has been accepted.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PERM_BITS = 3;
  localparam int PERM_RD   = 0;
  localparam int PERM_WR   = 1;
  localparam int PERM_EX   = 2;

endpackage

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_mode,
  input  logic trap_enter,
  input  logic mode_wr,
  input  logic mode_wdata,
  output logic map_on
);

  logic map_on_nxt;

  always_comb begin
    map_on_nxt = map_on;
    if (trap_enter) begin
      map_on_nxt = 1'b0;
    end else if (mode_wr && sup_mode) begin
      map_on_nxt = mode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_on <= 1'b0;
    end else begin
      map_on <= map_on_nxt;
    end
  end

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int IDX_W  = 2,
  parameter int BASE_W = 32,
  parameter int OFF_W  = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_go,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic [BASE_W-1:0]    ld_base,
  input  logic [OFF_W-1:0]     ld_limit,
  input  logic [PERM_BITS-1:0] ld_perm,
  input  logic                 ld_present,
  input  logic                 use_go,
  input  logic [IDX_W-1:0]     use_idx,
  input  logic                 use_write,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic [BASE_W-1:0]    lk_base,
  output logic [OFF_W-1:0]     lk_limit,
  output logic [PERM_BITS-1:0] lk_perm,
  output logic                 lk_present,
  input  logic [IDX_W-1:0]     st_idx,
  output logic                 st_touched,
  output logic                 st_written
);

  logic [BASE_W-1:0]    base_q    [NSEG];
  logic [OFF_W-1:0]     limit_q   [NSEG];
  logic [PERM_BITS-1:0] perm_q    [NSEG];
  logic                 present_q [NSEG];
  logic                 touched_q [NSEG];
  logic                 written_q [NSEG];

  logic [BASE_W-1:0]    base_d    [NSEG];
  logic [OFF_W-1:0]     limit_d   [NSEG];
  logic [PERM_BITS-1:0] perm_d    [NSEG];
  logic                 present_d [NSEG];
  logic                 touched_d [NSEG];
  logic                 written_d [NSEG];

  // a load of an entry wins over a usage update in the same cycle
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      base_d[i]    = base_q[i];
      limit_d[i]   = limit_q[i];
      perm_d[i]    = perm_q[i];
      present_d[i] = present_q[i];
      touched_d[i] = touched_q[i];
      written_d[i] = written_q[i];
      if (ld_go && (ld_idx == IDX_W'(i))) begin
        base_d[i]    = ld_base;
        limit_d[i]   = ld_limit;
        perm_d[i]    = ld_perm;
        present_d[i] = ld_present;
        touched_d[i] = 1'b0;
        written_d[i] = 1'b0;
      end else if (use_go && (use_idx == IDX_W'(i))) begin
        touched_d[i] = 1'b1;
        written_d[i] = written_q[i] | use_write;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]    <= '0;
        limit_q[i]   <= '0;
        perm_q[i]    <= '0;
        present_q[i] <= 1'b0;
        touched_q[i] <= 1'b0;
        written_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]    <= base_d[i];
        limit_q[i]   <= limit_d[i];
        perm_q[i]    <= perm_d[i];
        present_q[i] <= present_d[i];
        touched_q[i] <= touched_d[i];
        written_q[i] <= written_d[i];
      end
    end
  end

  assign lk_base    = base_q[lk_idx];
  assign lk_limit   = limit_q[lk_idx];
  assign lk_perm    = perm_q[lk_idx];
  assign lk_present = present_q[lk_idx];
  assign st_touched = touched_q[st_idx];
  assign st_written = written_q[st_idx];

endmodule

// File: rtl/seg_xlate_path.sv
module seg_xlate_path
  import seg_xlate_pkg::*;
#(
  parameter int PA_W   = 32,
  parameter int BASE_W = 32,
  parameter int OFF_W  = 30
) (
  input  logic [BASE_W-1:0]    base,
  input  logic [OFF_W-1:0]     limit,
  input  logic [PERM_BITS-1:0] perm,
  input  logic                 present,
  input  logic [OFF_W-1:0]     offset,
  input  acc_kind_e            kind,
  output logic [PA_W-1:0]      paddr,
  output logic                 seg_fault,
  output logic                 prot_fault
);

  logic over_limit;
  logic kind_ok;

  // sum and bound test both start from the raw offset: no serial dependency
  assign paddr      = PA_W'(base) + PA_W'(offset);
  assign over_limit = offset > limit;

  always_comb begin
    unique case (kind)
      ACC_READ:  kind_ok = perm[PERM_RD];
      ACC_WRITE: kind_ok = perm[PERM_WR];
      ACC_EXEC:  kind_ok = perm[PERM_EX];
      default:   kind_ok = 1'b0;
    endcase
  end

  assign seg_fault  = !present;
  assign prot_fault = present && (over_limit || !kind_ok);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 2,
  parameter int PA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [1:0]           req_kind,
  input  logic                 sup_mode,
  input  logic                 trap_enter,
  input  logic                 mode_wr,
  input  logic                 mode_wdata,
  input  logic                 ld_en,
  input  logic [SEG_W-1:0]     ld_idx,
  input  logic [PA_W-1:0]      ld_base,
  input  logic [VA_W-SEG_W-1:0] ld_limit,
  input  logic [PERM_BITS-1:0] ld_perm,
  input  logic                 ld_present,
  input  logic [SEG_W-1:0]     st_idx,
  output logic                 st_touched,
  output logic                 st_written,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_seg_fault,
  output logic                 rsp_prot_fault
);

  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ok = rst_pipe[1];

  logic             accept;
  logic [SEG_W-1:0] seg_idx;
  logic [OFF_W-1:0] offset;
  acc_kind_e        kind;
  logic             map_on;

  assign req_ready = rst_ok;
  assign accept    = req_valid && req_ready;
  assign seg_idx   = req_vaddr[VA_W-1 -: SEG_W];
  assign offset    = req_vaddr[OFF_W-1:0];
  assign kind      = acc_kind_e'(req_kind);

  seg_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_ok),
    .sup_mode   (sup_mode),
    .trap_enter (trap_enter),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .map_on     (map_on)
  );

  logic [PA_W-1:0]      lk_base;
  logic [OFF_W-1:0]     lk_limit;
  logic [PERM_BITS-1:0] lk_perm;
  logic                 lk_present;
  logic [PA_W-1:0]      map_paddr;
  logic                 map_seg_fault;
  logic                 map_prot_fault;
  logic                 use_go;

  assign use_go = accept && map_on && !map_seg_fault && !map_prot_fault;

  seg_desc_table #(
    .NSEG   (NSEG),
    .IDX_W  (SEG_W),
    .BASE_W (PA_W),
    .OFF_W  (OFF_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_ok),
    .ld_go      (ld_en && sup_mode),
    .ld_idx     (ld_idx),
    .ld_base    (ld_base),
    .ld_limit   (ld_limit),
    .ld_perm    (ld_perm),
    .ld_present (ld_present),
    .use_go     (use_go),
    .use_idx    (seg_idx),
    .use_write  (kind == ACC_WRITE),
    .lk_idx     (seg_idx),
    .lk_base    (lk_base),
    .lk_limit   (lk_limit),
    .lk_perm    (lk_perm),
    .lk_present (lk_present),
    .st_idx     (st_idx),
    .st_touched (st_touched),
    .st_written (st_written)
  );

  seg_xlate_path #(
    .PA_W   (PA_W),
    .BASE_W (PA_W),
    .OFF_W  (OFF_W)
  ) u_path (
    .base       (lk_base),
    .limit      (lk_limit),
    .perm       (lk_perm),
    .present    (lk_present),
    .offset     (offset),
    .kind       (kind),
    .paddr      (map_paddr),
    .seg_fault  (map_seg_fault),
    .prot_fault (map_prot_fault)
  );

  // response stage: next-state then register, address held by clock enable
  logic            rsp_valid_d;
  logic [PA_W-1:0] rsp_paddr_d;
  logic            rsp_seg_d;
  logic            rsp_prot_d;

  always_comb begin
    rsp_valid_d = accept;
    rsp_seg_d   = accept && map_on && map_seg_fault;
    rsp_prot_d  = accept && map_on && map_prot_fault;
    rsp_paddr_d = map_on ? map_paddr : PA_W'(req_vaddr);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid      <= 1'b0;
      rsp_seg_fault  <= 1'b0;
      rsp_prot_fault <= 1'b0;
      rsp_paddr      <= '0;
    end else begin
      rsp_valid      <= rsp_valid_d;
      rsp_seg_fault  <= rsp_seg_d;
      rsp_prot_fault <= rsp_prot_d;
      if (accept) begin
        rsp_paddr <= rsp_paddr_d;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            sup_mode,
  input logic            trap_enter,
  input logic            map_on,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_seg_fault,
  input logic            rsp_prot_fault
);

  p_rsp_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_needs_accept_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |-> $past(req_valid && req_ready));

  p_faults_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rsp_seg_fault && rsp_prot_fault));

  p_fault_with_rsp_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_seg_fault || rsp_prot_fault) |-> rsp_valid);

  p_bypass_identity_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_ready && !map_on) |=>
      (rsp_paddr == PA_W'($past(req_vaddr)) && !rsp_seg_fault && !rsp_prot_fault));

  p_trap_unmaps_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    trap_enter |=> !map_on);

  p_user_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sup_mode && !trap_enter) |=> $stable(map_on));

endmodule

bind seg_xlate_unit seg_xlate_checker #(
  .VA_W (VA_W),
  .PA_W (PA_W)
) u_checker (
  .clk            (clk),
  .rst_ok         (rst_ok),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .sup_mode       (sup_mode),
  .trap_enter     (trap_enter),
  .map_on         (map_on),
  .rsp_valid      (rsp_valid),
  .rsp_paddr      (rsp_paddr),
  .rsp_seg_fault  (rsp_seg_fault),
  .rsp_prot_fault (rsp_prot_fault)
);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        sup_mode = 1'b0;
  logic        trap_enter = 1'b0;
  logic        mode_wr = 1'b0;
  logic        mode_wdata = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_idx = '0;
  logic [31:0] ld_base = '0;
  logic [29:0] ld_limit = '0;
  logic [2:0]  ld_perm = '0;
  logic        ld_present = 1'b0;
  logic [1:0]  st_idx = '0;
  logic        st_touched;
  logic        st_written;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_seg_fault;
  logic        rsp_prot_fault;

  int applied = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .sup_mode(sup_mode),
    .trap_enter(trap_enter), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_limit(ld_limit),
    .ld_perm(ld_perm), .ld_present(ld_present), .st_idx(st_idx),
    .st_touched(st_touched), .st_written(st_written), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_seg_fault(rsp_seg_fault),
    .rsp_prot_fault(rsp_prot_fault)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] va;
    logic        segf;
    logic        protf;
    logic [31:0] pa;
  } vec_t;

  // kind: 00 read, 01 write, 10 exec, 11 reserved
  localparam vec_t VEC [12] = '{
    '{2'b00, 32'h0000_0010, 1'b0, 1'b0, 32'h1000_0010},  // R1 plain read
    '{2'b01, 32'h0000_0FFF, 1'b0, 1'b0, 32'h1000_0FFF},  // R2 offset == limit
    '{2'b00, 32'h0000_1000, 1'b0, 1'b1, 32'h0},          // R2 offset > limit
    '{2'b10, 32'h0000_0000, 1'b0, 1'b1, 32'h0},          // R3 no exec right
    '{2'b10, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h5FFF_FFFF},  // R1 largest offset
    '{2'b00, 32'h4000_0000, 1'b0, 1'b1, 32'h0},          // R3 no read right
    '{2'b00, 32'h8000_0100, 1'b0, 1'b0, 32'h0000_8100},  // R2 limit edge
    '{2'b01, 32'h8000_0000, 1'b0, 1'b1, 32'h0},          // R3 no write right
    '{2'b00, 32'hC000_0000, 1'b1, 1'b0, 32'h0},          // R4 missing
    '{2'b01, 32'hC000_0005, 1'b1, 1'b0, 32'h0},          // R4 priority
    '{2'b11, 32'h0000_0004, 1'b0, 1'b1, 32'h0},          // R3 reserved kind
    '{2'b00, 32'h0000_0020, 1'b0, 1'b0, 32'h1000_0020}   // R8 base untouched
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] kind, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input logic sup, input logic [1:0] idx, input logic [31:0] base,
                      input logic [29:0] lim, input logic [2:0] perm, input logic pres);
    @(negedge clk);
    sup_mode = sup; ld_en = 1'b1; ld_idx = idx; ld_base = base;
    ld_limit = lim; ld_perm = perm; ld_present = pres;
    @(negedge clk);
    ld_en = 1'b0; sup_mode = 1'b0;
  endtask

  task automatic set_mode(input logic sup, input logic val, input logic trap);
    @(negedge clk);
    sup_mode = sup; mode_wr = 1'b1; mode_wdata = val; trap_enter = trap;
    @(negedge clk);
    mode_wr = 1'b0; trap_enter = 1'b0; sup_mode = 1'b0;
  endtask

  task automatic flags(input string req, input logic [1:0] idx,
                       input logic exp_t, input logic exp_w);
    st_idx = idx;
    #1;
    check(req, "touched", 32'(st_touched), 32'(exp_t));
    check(req, "written", 32'(st_written), 32'(exp_w));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9", "ready in reset", 32'(req_ready), 32'd0);
    check("R9", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "ready after one edge", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R9", "ready after two edges", 32'(req_ready), 32'd1);

    load(1'b1, 2'd0, 32'h1000_0000, 30'h0000_0FFF, 3'b011, 1'b1);
    load(1'b1, 2'd1, 32'h2000_0000, 30'h3FFF_FFFF, 3'b100, 1'b1);
    load(1'b1, 2'd2, 32'h0000_8000, 30'h0000_0100, 3'b001, 1'b1);
    load(1'b1, 2'd3, 32'h0000_0000, 30'h0000_0000, 3'b000, 1'b0);
    flags("R5", 2'd0, 1'b0, 1'b0);

    // R6 mapping off after reset: identity, no fault, no flag change
    do_req(2'b01, 32'h0000_0010);
    check("R6", "bypass paddr", rsp_paddr, 32'h0000_0010);
    check("R6", "bypass faults", 32'({rsp_seg_fault, rsp_prot_fault}), 32'd0);
    flags("R6", 2'd0, 1'b0, 1'b0);

    // R8 user-mode loads and mode writes are ignored
    load(1'b0, 2'd0, 32'hAAAA_0000, 30'h3FFF_FFFF, 3'b111, 1'b1);
    load(1'b0, 2'd3, 32'h0, 30'h3FFF_FFFF, 3'b111, 1'b1);
    set_mode(1'b0, 1'b1, 1'b0);
    do_req(2'b00, 32'hC000_0123);
    check("R8", "user mode write ignored", rsp_paddr, 32'hC000_0123);
    check("R8", "still unmapped", 32'({rsp_seg_fault, rsp_prot_fault}), 32'd0);

    set_mode(1'b1, 1'b1, 1'b0);
    foreach (VEC[i]) begin
      do_req(VEC[i].kind, VEC[i].va);
      check("R1", "rsp_valid", 32'(rsp_valid), 32'd1);
      check("R4", "seg fault", 32'(rsp_seg_fault), 32'(VEC[i].segf));
      check("R3", "prot fault", 32'(rsp_prot_fault), 32'(VEC[i].protf));
      if (!VEC[i].segf && !VEC[i].protf)
        check("R1", "paddr", rsp_paddr, VEC[i].pa);
    end
    @(negedge clk);
    check("R1", "rsp_valid one cycle", 32'(rsp_valid), 32'd0);

    // R5 usage flags after the table
    flags("R5", 2'd0, 1'b1, 1'b1);
    flags("R5", 2'd1, 1'b1, 1'b0);
    flags("R5", 2'd2, 1'b1, 1'b0);
    flags("R5", 2'd3, 1'b0, 1'b0);

    // R7 trap wins over a simultaneous enable
    set_mode(1'b1, 1'b1, 1'b1);
    do_req(2'b00, 32'h0000_0010);
    check("R7", "trap forces bypass", rsp_paddr, 32'h0000_0010);

    // R5 reload clears flags
    load(1'b1, 2'd0, 32'h1000_0000, 30'h0000_0FFF, 3'b011, 1'b1);
    flags("R5", 2'd0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule